// File: doc/BRIEF.md
# Background and Sprite Pixel Compositor

This block sits at the end of a tile-based video pipeline and runs at pixel rate. Each dot it takes one background pixel, made of a 2-bit pattern value and a 2-bit palette select, and one sprite pixel, made of a pattern value, a palette select, a priority flag and a flag that marks the first sprite in the table. It also takes the current column and the display mask. From these it picks the palette entry to read. It reports a sprite-zero collision, and it can either drive the low nibble of the chosen entry out on a 4-bit external port or take the backdrop from that port.

The selection result is registered once. The palette index, the collision pulse, the external port and the emphasis bits therefore describe the dot that was presented one clock earlier. The palette RAM sits outside the block. Its read data, and the data returned to the host data port, come back through a monochrome mask that is purely combinational.

Mask byte layout used throughout:
- bit 0: monochrome.
- bit 1: show background in the left columns.
- bit 2: show sprites in the left columns.
- bit 3: background enable.
- bit 4: sprite enable.
- bits 7..5: blue, green and red emphasis.

Top module: `pix_compositor`

## Requirements
- R1: When mask bit 1 is 0, a background pixel at a column below 8 is not drawn and counts as transparent. Columns 8 and above are unaffected.
- R2: When mask bit 2 is 0, a sprite pixel at a column below 8 is not drawn and counts as transparent.
- R3: When mask bit 3 is 0, no background pixel is drawn. When mask bit 4 is 0, no sprite pixel is drawn.
- R4: A background pattern value of 0 is transparent and values 1 to 3 are opaque. A drawn opaque background selects index {1'b0, palette, pattern}, in the range 0x00 to 0x0F.
- R5: A drawn opaque sprite selects index {1'b1, palette, pattern}, in the range 0x10 to 0x1F. The sprite wins when its priority flag is 0 (in front) or when the background is transparent. Otherwise the background wins.
- R6: When neither layer is drawn opaque, the index is the backdrop. The backdrop is 0 when the external-drive bit is 1, and {1'b0, ext_in_i} when that bit is 0.
- R7: hit_o pulses for one cycle, one clock after a dot in which all of the following hold: the sprite-zero flag is set, both layers are drawn opaque, and the column is not 255. The sprite priority flag does not affect this.
- R8: ext_oe_o follows the external-drive bit. While it is 1, ext_out_o carries the low 4 bits of the selected index. Otherwise ext_out_o is 0. Both are delayed by one clock.
- R9: While mask bit 0 is 1, colour_o and cpu_data_o are the palette data inputs ANDed with 0x30. Otherwise they pass unchanged. There is no clock delay on this path.
- R10: emph_o carries mask bits 7..5, delayed by one clock.
- R11: While rst_ni is low, pal_idx_o, hit_o, ext_out_o, ext_oe_o and emph_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_i | input | 8 | Display mask byte |
| ext_drive_i | input | 1 | 1 = drive the external port, 0 = take the backdrop from it |
| ext_in_i | input | 4 | External backdrop input |
| col_i | input | 8 | Current pixel column |
| bg_pat_i | input | 2 | Background pattern value |
| bg_pal_i | input | 2 | Background palette select |
| spr_pat_i | input | 2 | Sprite pattern value |
| spr_pal_i | input | 2 | Sprite palette select |
| spr_behind_i | input | 1 | 1 = sprite sits behind an opaque background |
| spr_zero_i | input | 1 | Sprite pixel belongs to sprite zero |
| pal_data_i | input | 6 | Palette RAM read data for rendering |
| cpu_data_i | input | 6 | Palette RAM read data for the host data port |
| pal_idx_o | output | 5 | Selected palette index |
| colour_o | output | 6 | Masked rendering colour |
| cpu_data_o | output | 6 | Masked host read data |
| ext_out_o | output | 4 | External port output |
| ext_oe_o | output | 1 | External port output enable |
| emph_o | output | 3 | Emphasis bits {blue, green, red} |
| hit_o | output | 1 | Sprite-zero hit pulse |

## Verification
There are two timing groups. The index, the hit pulse, the external port and the emphasis bits change at the first rising edge after a dot is presented. The masked colour paths change in the same cycle as their inputs.

The bench drives each dot on a falling edge and computes the expected registered results from the inputs it just applied. It compares those results at the next falling edge, which is after exactly one rising edge. It checks the combinational colour paths a short delay after driving, before that rising edge.

// File: rtl/pix_comp_pkg.sv
package pix_comp_pkg;
  localparam int unsigned PAT_W   = 2;
  localparam int unsigned PAL_W   = 2;
  localparam int unsigned IDX_W   = 1 + PAL_W + PAT_W;
  localparam int unsigned CLR_W   = 6;
  localparam int unsigned EXT_W   = 4;
  localparam int unsigned COL_W   = 8;
  localparam int unsigned N_LAYER = 2;

  // mask byte bit positions
  localparam int unsigned M_MONO    = 0;
  localparam int unsigned M_BG_LEFT = 1;
  localparam int unsigned M_SP_LEFT = 2;
  localparam int unsigned M_BG_EN   = 3;
  localparam int unsigned M_SP_EN   = 4;
  localparam int unsigned M_EMPH_LO = 5;
  localparam int unsigned EMPH_W    = 3;

  typedef enum logic [1:0] {
    SRC_BACKDROP = 2'd0,
    SRC_BG       = 2'd1,
    SRC_SPR      = 2'd2
  } pix_src_e;

  typedef struct packed {
    logic [PAL_W-1:0] pal;
    logic [PAT_W-1:0] pat;
  } layer_px_t;
endpackage

// File: rtl/pix_layer_gate.sv
module pix_layer_gate
  import pix_comp_pkg::*;
#(
  parameter int unsigned CW        = COL_W,
  parameter int unsigned CLIP_COLS = 8
) (
  input  layer_px_t       px_i,
  input  logic            en_i,
  input  logic            show_left_i,
  input  logic [CW-1:0]   col_i,
  output logic            opaque_o,
  output layer_px_t       px_o
);
  localparam logic [CW-1:0] CLIP_LIM = CW'(CLIP_COLS);

  logic in_left;
  logic drawn;

  assign in_left  = (col_i < CLIP_LIM);
  assign drawn    = en_i && (show_left_i || !in_left);
  assign opaque_o = drawn && (px_i.pat != '0);
  assign px_o     = opaque_o ? px_i : '0;
endmodule

// File: rtl/pix_prio_sel.sv
module pix_prio_sel
  import pix_comp_pkg::*;
(
  input  layer_px_t        bg_i,
  input  logic             bg_op_i,
  input  layer_px_t        sp_i,
  input  logic             sp_op_i,
  input  logic             sp_behind_i,
  input  logic             ext_drive_i,
  input  logic [EXT_W-1:0] ext_in_i,
  output logic [IDX_W-1:0] idx_o,
  output pix_src_e         src_o
);
  logic [IDX_W-1:0] backdrop;

  assign backdrop = ext_drive_i ? '0 : IDX_W'(ext_in_i);

  always_comb begin
    if (sp_op_i && (!sp_behind_i || !bg_op_i)) src_o = SRC_SPR;
    else if (bg_op_i)                          src_o = SRC_BG;
    else                                       src_o = SRC_BACKDROP;
  end

  always_comb begin
    unique case (src_o)
      SRC_SPR:  idx_o = {1'b1, sp_i};
      SRC_BG:   idx_o = {1'b0, bg_i};
      default:  idx_o = backdrop;
    endcase
  end
endmodule

// File: rtl/pix_hit_detect.sv
module pix_hit_detect
  import pix_comp_pkg::*;
#(
  parameter int unsigned CW = COL_W
) (
  input  logic          bg_op_i,
  input  logic          sp_op_i,
  input  logic          sp_zero_i,
  input  logic [CW-1:0] col_i,
  output logic          hit_o
);
  localparam logic [CW-1:0] LAST_COL = '1;

  assign hit_o = sp_zero_i && sp_op_i && bg_op_i && (col_i != LAST_COL);
endmodule

// File: rtl/pix_mono_mask.sv
module pix_mono_mask
  import pix_comp_pkg::*;
#(
  parameter int unsigned W       = CLR_W,
  parameter int unsigned N_PATHS = 2
) (
  input  logic                    mono_i,
  input  logic [N_PATHS-1:0][W-1:0] d_i,
  output logic [N_PATHS-1:0][W-1:0] d_o
);
  // keep only the two luminance bits
  localparam logic [W-1:0] KEEP = {2'b11, {(W-2){1'b0}}};

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    assign d_o[p] = mono_i ? (d_i[p] & KEEP) : d_i[p];
  end
endmodule

// File: rtl/pix_compositor.sv
module pix_compositor
  import pix_comp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [7:0]         mask_i,
  input  logic               ext_drive_i,
  input  logic [EXT_W-1:0]   ext_in_i,
  input  logic [COL_W-1:0]   col_i,
  input  logic [PAT_W-1:0]   bg_pat_i,
  input  logic [PAL_W-1:0]   bg_pal_i,
  input  logic [PAT_W-1:0]   spr_pat_i,
  input  logic [PAL_W-1:0]   spr_pal_i,
  input  logic               spr_behind_i,
  input  logic               spr_zero_i,
  input  logic [CLR_W-1:0]   pal_data_i,
  input  logic [CLR_W-1:0]   cpu_data_i,
  output logic [IDX_W-1:0]   pal_idx_o,
  output logic [CLR_W-1:0]   colour_o,
  output logic [CLR_W-1:0]   cpu_data_o,
  output logic [EXT_W-1:0]   ext_out_o,
  output logic               ext_oe_o,
  output logic [EMPH_W-1:0]  emph_o,
  output logic               hit_o
);
  localparam int unsigned L_BG = 0;
  localparam int unsigned L_SP = 1;

  layer_px_t              px_in  [N_LAYER];
  layer_px_t              px_gt  [N_LAYER];
  logic [N_LAYER-1:0]     lay_en;
  logic [N_LAYER-1:0]     lay_left;
  logic [N_LAYER-1:0]     lay_op;

  assign px_in[L_BG]    = '{pal: bg_pal_i,  pat: bg_pat_i};
  assign px_in[L_SP]    = '{pal: spr_pal_i, pat: spr_pat_i};
  assign lay_en[L_BG]   = mask_i[M_BG_EN];
  assign lay_en[L_SP]   = mask_i[M_SP_EN];
  assign lay_left[L_BG] = mask_i[M_BG_LEFT];
  assign lay_left[L_SP] = mask_i[M_SP_LEFT];

  for (genvar l = 0; l < N_LAYER; l++) begin : g_layer
    pix_layer_gate #(.CW(COL_W), .CLIP_COLS(8)) u_gate (
      .px_i        (px_in[l]),
      .en_i        (lay_en[l]),
      .show_left_i (lay_left[l]),
      .col_i       (col_i),
      .opaque_o    (lay_op[l]),
      .px_o        (px_gt[l])
    );
  end

  logic [IDX_W-1:0] idx_d;
  pix_src_e         src_d;
  logic             hit_d;

  pix_prio_sel u_sel (
    .bg_i        (px_gt[L_BG]),
    .bg_op_i     (lay_op[L_BG]),
    .sp_i        (px_gt[L_SP]),
    .sp_op_i     (lay_op[L_SP]),
    .sp_behind_i (spr_behind_i),
    .ext_drive_i (ext_drive_i),
    .ext_in_i    (ext_in_i),
    .idx_o       (idx_d),
    .src_o       (src_d)
  );

  pix_hit_detect #(.CW(COL_W)) u_hit (
    .bg_op_i   (lay_op[L_BG]),
    .sp_op_i   (lay_op[L_SP]),
    .sp_zero_i (spr_zero_i),
    .col_i     (col_i),
    .hit_o     (hit_d)
  );

  logic [1:0][CLR_W-1:0] mm_in, mm_out;
  assign mm_in = {cpu_data_i, pal_data_i};

  pix_mono_mask #(.W(CLR_W), .N_PATHS(2)) u_mono (
    .mono_i (mask_i[M_MONO]),
    .d_i    (mm_in),
    .d_o    (mm_out)
  );

  assign colour_o   = mm_out[0];
  assign cpu_data_o = mm_out[1];

  logic [EXT_W-1:0] ext_d;
  assign ext_d = ext_drive_i ? idx_d[EXT_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pal_idx_o <= '0;
      hit_o     <= 1'b0;
      ext_out_o <= '0;
      ext_oe_o  <= 1'b0;
      emph_o    <= '0;
    end else begin
      pal_idx_o <= idx_d;
      hit_o     <= hit_d;
      ext_out_o <= ext_d;
      ext_oe_o  <= ext_drive_i;
      emph_o    <= mask_i[M_EMPH_LO +: EMPH_W];
    end
  end

  logic unused_src;
  assign unused_src = ^src_d;
endmodule

// File: rtl/pix_compositor_chk.sv
module pix_compositor_chk
  import pix_comp_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [7:0]         mask_i,
  input logic               ext_drive_i,
  input logic [COL_W-1:0]   col_i,
  input logic [PAT_W-1:0]   bg_pat_i,
  input logic [PAT_W-1:0]   spr_pat_i,
  input logic               spr_zero_i,
  input logic [IDX_W-1:0]   pal_idx_o,
  input logic [CLR_W-1:0]   colour_o,
  input logic [EXT_W-1:0]   ext_out_o,
  input logic               ext_oe_o,
  input logic [EMPH_W-1:0]  emph_o,
  input logic               hit_o
);
  // R7
  hit_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> ($past(spr_zero_i) && $past(spr_pat_i) != '0 &&
                      $past(bg_pat_i) != '0 && $past(col_i) != 8'hFF));

  // R8
  ext_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_oe_o |-> (ext_out_o == '0));

  // R9
  mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i[0] |-> (colour_o[3:0] == 4'h0));

  // R5
  spr_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_pat_i == '0 || !mask_i[4]) && ext_drive_i |=> !pal_idx_o[IDX_W-1]);

  // R10
  emph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (emph_o == $past(mask_i[7:5])));

  // R1
  bg_clip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_i[1] && !mask_i[2] && col_i < 8'd8 && ext_drive_i) |=> (pal_idx_o == '0));
endmodule

bind pix_compositor pix_compositor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mask_i      (mask_i),
  .ext_drive_i (ext_drive_i),
  .col_i       (col_i),
  .bg_pat_i    (bg_pat_i),
  .spr_pat_i   (spr_pat_i),
  .spr_zero_i  (spr_zero_i),
  .pal_idx_o   (pal_idx_o),
  .colour_o    (colour_o),
  .ext_out_o   (ext_out_o),
  .ext_oe_o    (ext_oe_o),
  .emph_o      (emph_o),
  .hit_o       (hit_o)
);

// File: tb/pix_compositor_tb_top.sv
module pix_compositor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mask = '0;
  logic       drv = 1'b0;
  logic [3:0] xin = '0;
  logic [7:0] col = '0;
  logic [1:0] bp = '0, bpl = '0, sp = '0, spl = '0;
  logic       beh = 1'b0, sz = 1'b0;
  logic [5:0] pdat = '0, cdat = '0;
  logic [4:0] idx;
  logic [5:0] colr, cout;
  logic [3:0] xout;
  logic       xoe, hit;
  logic [2:0] emph;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pix_compositor dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mask_i(mask), .ext_drive_i(drv), .ext_in_i(xin),
    .col_i(col), .bg_pat_i(bp), .bg_pal_i(bpl), .spr_pat_i(sp), .spr_pal_i(spl),
    .spr_behind_i(beh), .spr_zero_i(sz), .pal_data_i(pdat), .cpu_data_i(cdat),
    .pal_idx_o(idx), .colour_o(colr), .cpu_data_o(cout), .ext_out_o(xout),
    .ext_oe_o(xoe), .emph_o(emph), .hit_o(hit)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] m, input logic d,
                      input logic [3:0] x, input int c, input logic [1:0] b,
                      input logic [1:0] bl, input logic [1:0] s, input logic [1:0] sl,
                      input logic be, input logic z);
    int bg_op, sp_op, e_idx, e_hit, e_xo;
    int mono_keep;
    mask = m; drv = d; xin = x; col = 8'(c); bp = b; bpl = bl; sp = s; spl = sl;
    beh = be; sz = z;
    pdat = 6'($urandom); cdat = 6'($urandom);
    bg_op = (b != 0) && m[3] && (m[1] || c >= 8);
    sp_op = (s != 0) && m[4] && (m[2] || c >= 8);
    if (sp_op && (!be || !bg_op)) e_idx = 16 + sl * 4 + s;
    else if (bg_op)               e_idx = bl * 4 + b;
    else                          e_idx = d ? 0 : x;
    e_hit = z && sp_op && bg_op && (c != 255);
    e_xo  = d ? (e_idx % 16) : 0;
    mono_keep = m[0] ? 'h30 : 'h3F;
    #1;
    chk("R9", "colour", colr, pdat & mono_keep);
    chk("R9", "cpu_data", cout, cdat & mono_keep);
    @(negedge clk);
    chk(tag, "index", idx, e_idx);
    chk("R7", "hit", hit, e_hit);
    chk("R8", "ext_out", xout, e_xo);
    chk("R8", "ext_oe", xoe, d);
    chk("R10", "emph", emph, m[7:5]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    mask = 8'hFF; drv = 1'b1; bp = 2'd3; sp = 2'd3; sz = 1'b1; col = 8'd50;
    repeat (3) @(negedge clk);
    // R11 outputs held at zero in reset
    chk("R11", "idx", idx, 0);
    chk("R11", "hit", hit, 0);
    chk("R11", "ext_oe", xoe, 0);
    chk("R11", "emph", emph, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 background opacity and index
    step("R4", 8'h1E, 1, 4'h0, 40, 2'd0, 2'd3, 2'd0, 2'd0, 0, 0);
    step("R4", 8'h1E, 1, 4'h0, 40, 2'd2, 2'd3, 2'd0, 2'd0, 0, 0);
    // R5 priority
    step("R5", 8'h1E, 1, 4'h0, 40, 2'd1, 2'd1, 2'd2, 2'd2, 0, 0);
    step("R5", 8'h1E, 1, 4'h0, 40, 2'd1, 2'd1, 2'd2, 2'd2, 1, 0);
    step("R5", 8'h1E, 1, 4'h0, 40, 2'd0, 2'd1, 2'd3, 2'd1, 1, 0);
    // R1 background clipping
    step("R1", 8'h1C, 1, 4'h0, 3,  2'd3, 2'd2, 2'd0, 2'd0, 0, 0);
    step("R1", 8'h1C, 1, 4'h0, 7,  2'd3, 2'd2, 2'd0, 2'd0, 0, 0);
    step("R1", 8'h1C, 1, 4'h0, 8,  2'd3, 2'd2, 2'd0, 2'd0, 0, 0);
    // R2 sprite clipping
    step("R2", 8'h1A, 1, 4'h0, 7,  2'd0, 2'd0, 2'd1, 2'd3, 0, 0);
    step("R2", 8'h1A, 1, 4'h0, 8,  2'd0, 2'd0, 2'd1, 2'd3, 0, 0);
    // R3 layer enables
    step("R3", 8'h16, 1, 4'h0, 90, 2'd2, 2'd2, 2'd0, 2'd0, 0, 0);
    step("R3", 8'h0E, 1, 4'h0, 90, 2'd0, 2'd0, 2'd2, 2'd2, 0, 0);
    // R6 external backdrop
    step("R6", 8'h1E, 0, 4'h9, 60, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    step("R6", 8'h1E, 0, 4'h9, 60, 2'd1, 2'd2, 2'd0, 2'd0, 0, 0);
    step("R6", 8'h1E, 1, 4'h9, 60, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0);
    // R7 hit: behind sprite still hits, column 255 and clipped do not
    step("R7", 8'h1E, 1, 4'h0, 100, 2'd1, 2'd0, 2'd1, 2'd0, 1, 1);
    step("R7", 8'h1E, 1, 4'h0, 255, 2'd1, 2'd0, 2'd1, 2'd0, 0, 1);
    step("R7", 8'h18, 1, 4'h0, 4,   2'd1, 2'd0, 2'd1, 2'd0, 0, 1);
    step("R7", 8'h1E, 1, 4'h0, 254, 2'd1, 2'd0, 2'd1, 2'd0, 0, 1);
    // R8 external drive of low nibble
    step("R8", 8'h1E, 1, 4'h0, 30, 2'd3, 2'd3, 2'd0, 2'd0, 0, 0);
    // R9 mono and R10 emphasis
    step("R9", 8'h1F, 1, 4'h0, 30, 2'd1, 2'd1, 2'd0, 2'd0, 0, 0);
    step("R10", 8'hBE, 1, 4'h0, 30, 2'd1, 2'd1, 2'd0, 2'd0, 0, 0);
    step("R10", 8'h7F, 1, 4'h0, 30, 2'd1, 2'd1, 2'd0, 2'd0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      step("R5", 8'($urandom), 1'($urandom), 4'($urandom),
           ((i % 7) == 0) ? 255 : int'($urandom_range(0, 255)),
           2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule